// File: doc/BRIEF.md
# CAN frame field parser

This block follows a classic CAN data or remote frame one bus bit at a time and breaks it into its fields. Upstream logic has already done bit timing and sampling. It presents one sampled level per `bit_valid` strobe, with dominant encoded as 0 and recessive as 1. The parser removes stuff bits and works out whether the frame uses the 11-bit or the 29-bit identifier layout. It computes the data field length from the length code while the frame is arriving, and it checks the CRC against its own running value.

When the last end-of-frame bit is accepted, `frame_done` pulses for one cycle. At that moment every frame output is valid, and the outputs then hold until the next start of frame. A format violation or a stuffing violation produces a one-cycle error pulse. The frame is then abandoned and the parser goes back to waiting for a start-of-frame bit.

Top module: `can_frame_parser`

## Requirements
- R1: After reset, `frame_done`, `form_error`, `stuff_error`, `crc_error` and `ack_seen` are low, and `frame_id`, `frame_dlc`, `frame_data` and `crc_rx` are zero.
- R2: The parser advances only on cycles with `bit_valid` high. The value on `bit_in` in any other cycle has no effect on the decoded frame.
- R3: While waiting for a frame, a dominant bit (0) is taken as start of frame. A recessive bit (1) gives a one-cycle `form_error` pulse, and the parser keeps waiting.
- R4: In the standard layout (identifier-extension bit, frame bit 13, is dominant), `frame_id[10:0]` holds the 11 identifier bits that follow start of frame, MSB first, and `frame_id[28:11]` is zero. `frame_ext` is 0. `frame_remote` is the level of frame bit 12. `frame_dlc` holds frame bits 15 to 18, MSB first.
- R5: In the extended layout (frame bit 13 recessive), `frame_id` equals the 11-bit base identifier shifted left by 18 and ORed with the 18-bit extension in frame bits 14 to 31. `frame_ext` is 1. `frame_remote` is the level of frame bit 32. `frame_dlc` holds frame bits 35 to 38.
- R6: The data field carries min(DLC, 8) bytes, or no bytes in a remote frame. Byte 0 lands in `frame_data[63:56]`, byte 1 in `[55:48]` and so on, each byte MSB first. Bytes that were not received read as zero.
- R7: From start of frame through the last CRC bit, once five equal bits in a row have arrived, the next bit is a stuff bit and is dropped from field counting. If that bit has the same level as the five before it, `stuff_error` pulses once and the frame is abandoned.
- R8: `crc_rx` holds the 15 received CRC bits, MSB first. With `frame_done`, `crc_error` goes to 1 exactly when `crc_rx` differs from the CRC of start of frame through the last data bit (polynomial 0x4599, initial value 0).
- R9: With `frame_done`, `ack_seen` is 1 if the ACK slot was dominant and 0 if it was recessive.
- R10: A dominant CRC delimiter, a dominant ACK delimiter or a dominant end-of-frame bit gives a one-cycle `form_error` pulse. The frame is abandoned without `frame_done`.
- R11: `frame_done` pulses for one cycle, in the cycle after the seventh end-of-frame bit is accepted. The next valid bit is treated as a new start of frame.
- R12: The reserved bits of both layouts, and the extended layout's bit 12, are accepted at either level and do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Strobe marking a sampled bus bit on `bit_in` |
| bit_in | input | 1 | Sampled bus level, 0 dominant, 1 recessive |
| frame_done | output | 1 | One-cycle pulse when a complete frame has been parsed |
| frame_id | output | 29 | Identifier, standard layout right-aligned |
| frame_ext | output | 1 | 1 for the extended identifier layout |
| frame_remote | output | 1 | 1 for a remote frame |
| frame_dlc | output | 4 | Data length code as received |
| frame_data | output | 64 | Data bytes, byte 0 in the top byte |
| crc_rx | output | 15 | Received CRC sequence |
| crc_error | output | 1 | Received CRC differs from computed CRC |
| ack_seen | output | 1 | ACK slot was dominant |
| form_error | output | 1 | One-cycle pulse on a fixed-form bit violation |
| stuff_error | output | 1 | One-cycle pulse on a stuffing violation |

## Verification
The assertions take three things for granted. The upstream stream begins at a start-of-frame bit. It carries exactly one already sampled level per strobe. No idle recessive bits appear between frames, because each of them would count as a start-of-frame violation. The stimulus generator therefore builds every frame from start of frame to the last end-of-frame bit, applying the stuffing rule and the CRC itself. When it deliberately breaks a frame, it stops sending right after the bad bit, so the unsent tail never shows up as spurious start-of-frame errors. During strobe-free cycles it drives the inverted level on `bit_in`, so any leak of unstrobed bits would corrupt a decoded field.

// File: rtl/can_parse_pkg.sv
package can_parse_pkg;

  // Field widths fixed by the frame format
  localparam int ID_BASE_W = 11;
  localparam int ID_EXT_W  = 18;
  localparam int ID_W      = ID_BASE_W + ID_EXT_W;
  localparam int DLC_W     = 4;
  localparam int MAX_BYTES = 8;
  localparam int DATA_W    = MAX_BYTES * 8;
  localparam int DIDX_W    = $clog2(DATA_W);
  localparam int CRC_W     = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;

  // Stuffing rule
  localparam int STUFF_RUN = 5;
  localparam int RUN_W     = $clog2(STUFF_RUN + 1);

  // Header positions (unstuffed bit index, SOF = 0)
  localparam int POS_B12       = ID_BASE_W + 1;
  localparam int POS_IDE       = POS_B12 + 1;
  localparam int STD_DLC_START = POS_IDE + 2;
  localparam int STD_DLC_END   = STD_DLC_START + DLC_W - 1;
  localparam int EXT_ID_END    = POS_IDE + ID_EXT_W;
  localparam int EXT_RTR       = EXT_ID_END + 1;
  localparam int EXT_DLC_START = EXT_RTR + 3;
  localparam int EXT_DLC_END   = EXT_DLC_START + DLC_W - 1;

  // Tail offsets, relative to the last data bit
  localparam int EOF_LEN      = 7;
  localparam int OFS_CRC_END  = CRC_W;
  localparam int OFS_CDEL     = OFS_CRC_END + 1;
  localparam int OFS_ACK      = OFS_CDEL + 1;
  localparam int OFS_ADEL     = OFS_ACK + 1;
  localparam int OFS_EOF_LAST = OFS_ADEL + EOF_LEN;

  localparam int MAX_POS = EXT_DLC_END + DATA_W + OFS_EOF_LAST;
  localparam int POS_W   = $clog2(MAX_POS + 1);

  typedef enum logic [1:0] {
    PH_SOF  = 2'd0,
    PH_HEAD = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;

endpackage

// File: rtl/can_bit_destuff.sv
module can_bit_destuff
  import can_parse_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid_i,
  input  logic in_bit_i,
  input  logic restart_i,
  input  logic zone_i,
  output logic out_valid_o,
  output logic stuff_err_o
);

  logic [RUN_W-1:0] run_q, run_d;
  logic             last_q, last_d;
  logic             at_limit;

  assign at_limit = zone_i && !restart_i && (run_q == RUN_W'(STUFF_RUN));

  always_comb begin
    run_d       = run_q;
    last_d      = last_q;
    out_valid_o = 1'b0;
    stuff_err_o = 1'b0;
    if (in_valid_i) begin
      if (restart_i) begin
        run_d       = RUN_W'(1);
        last_d      = in_bit_i;
        out_valid_o = 1'b1;
      end else if (at_limit) begin
        if (in_bit_i == last_q) begin
          stuff_err_o = 1'b1;
        end else begin
          run_d  = RUN_W'(1);
          last_d = in_bit_i;
        end
      end else begin
        out_valid_o = 1'b1;
        if (in_bit_i != last_q) begin
          run_d  = RUN_W'(1);
          last_d = in_bit_i;
        end else if (run_q < RUN_W'(STUFF_RUN)) begin
          run_d = run_q + RUN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b1;
    end else if (in_valid_i) begin
      run_q  <= run_d;
      last_q <= last_d;
    end
  end

  // R7: the run length never exceeds the stuffing limit
  a_r7_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(STUFF_RUN));

  // R7: a stuff bit is never forwarded to field decoding
  a_r7_stuff_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && zone_i && !restart_i && run_q == RUN_W'(STUFF_RUN)) |-> !out_valid_o);

endmodule

// File: rtl/can_crc15.sv
module can_crc15
  import can_parse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);

  logic [CRC_W-1:0] crc_q, crc_d, seed;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    crc_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  always_comb begin
    seed  = start_i ? '0 : crc_q;
    crc_d = crc_step(seed, bit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (en_i) begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;

  // R8: the running CRC only moves on covered bits
  a_r8_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(crc_q));

endmodule

// File: rtl/can_field_track.sv
module can_field_track
  import can_parse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              stuff_err_i,
  input  logic [CRC_W-1:0]  crc_calc_i,
  output logic              restart_o,
  output logic              zone_o,
  output logic              crc_en_o,
  output logic              crc_start_o,
  output logic              done_o,
  output logic [ID_W-1:0]   id_o,
  output logic              ext_o,
  output logic              remote_o,
  output logic [DLC_W-1:0]  dlc_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CRC_W-1:0]  crc_rx_o,
  output logic              crc_err_o,
  output logic              ack_o,
  output logic              form_err_o,
  output logic              stuff_err_o
);

  localparam logic [POS_W-1:0] P_BASE_END  = POS_W'(ID_BASE_W);
  localparam logic [POS_W-1:0] P_B12       = POS_W'(POS_B12);
  localparam logic [POS_W-1:0] P_IDE       = POS_W'(POS_IDE);
  localparam logic [POS_W-1:0] P_SDLC_BEG  = POS_W'(STD_DLC_START);
  localparam logic [POS_W-1:0] P_SDLC_END  = POS_W'(STD_DLC_END);
  localparam logic [POS_W-1:0] P_EID_END   = POS_W'(EXT_ID_END);
  localparam logic [POS_W-1:0] P_ERTR      = POS_W'(EXT_RTR);
  localparam logic [POS_W-1:0] P_EDLC_BEG  = POS_W'(EXT_DLC_START);
  localparam logic [POS_W-1:0] P_EDLC_END  = POS_W'(EXT_DLC_END);
  localparam logic [POS_W-1:0] O_CRC_END   = POS_W'(OFS_CRC_END);
  localparam logic [POS_W-1:0] O_CDEL      = POS_W'(OFS_CDEL);
  localparam logic [POS_W-1:0] O_ACK       = POS_W'(OFS_ACK);
  localparam logic [POS_W-1:0] O_ADEL      = POS_W'(OFS_ADEL);
  localparam logic [POS_W-1:0] O_EOF_LAST  = POS_W'(OFS_EOF_LAST);
  localparam logic [POS_W:0]   ZONE_OFS    = (POS_W+1)'(OFS_CDEL);
  localparam logic [POS_W-1:0] MAX_LAST    = POS_W'(EXT_DLC_END + DATA_W);

  phase_e                phase_q, phase_d;
  logic [POS_W-1:0]      pos_q, pos_d;
  logic [POS_W-1:0]      last_q, last_d;
  logic [ID_BASE_W-1:0]  base_q, base_d;
  logic [ID_EXT_W-1:0]   ext_q, ext_d;
  logic                  b12_q, b12_d;
  logic                  ide_q, ide_d;
  logic                  rtr_q, rtr_d;
  logic [DLC_W-1:0]      dlc_q, dlc_d;
  logic [DATA_W-1:0]     data_q, data_d;
  logic [CRC_W-1:0]      crcrx_q, crcrx_d;
  logic                  ack_q, ack_d;
  logic                  done_q, done_d;
  logic                  crcerr_q, crcerr_d;
  logic                  form_q, form_d;
  logic                  stuff_q, stuff_d;

  logic [POS_W-1:0]      rel;
  logic [POS_W-1:0]      first_data;
  logic [DIDX_W-1:0]     didx;
  logic [DLC_W-1:0]      dlc_full;

  // Number of data bits implied by a length code
  function automatic logic [POS_W-1:0] data_span(input logic [DLC_W-1:0] d, input logic remote);
    if (remote)
      data_span = '0;
    else if (d > DLC_W'(MAX_BYTES))
      data_span = POS_W'(DATA_W);
    else
      data_span = POS_W'({d, 3'b000});
  endfunction

  assign rel        = pos_q - last_q;
  assign first_data = (ide_q ? P_EDLC_END : P_SDLC_END) + POS_W'(1);
  assign didx       = DIDX_W'(DATA_W - 1) - DIDX_W'(pos_q - first_data);
  assign dlc_full   = {dlc_q[DLC_W-2:0], bit_i};

  assign restart_o = (phase_q == PH_SOF);
  assign zone_o    = (phase_q != PH_TAIL) || ({1'b0, pos_q} <= ({1'b0, last_q} + ZONE_OFS));

  // Next-state logic
  always_comb begin
    phase_d     = phase_q;
    pos_d       = pos_q;
    last_d      = last_q;
    base_d      = base_q;
    ext_d       = ext_q;
    b12_d       = b12_q;
    ide_d       = ide_q;
    rtr_d       = rtr_q;
    dlc_d       = dlc_q;
    data_d      = data_q;
    crcrx_d     = crcrx_q;
    ack_d       = ack_q;
    crcerr_d    = crcerr_q;
    done_d      = 1'b0;
    form_d      = 1'b0;
    stuff_d     = 1'b0;
    crc_en_o    = 1'b0;
    crc_start_o = 1'b0;

    if (stuff_err_i) begin
      stuff_d = 1'b1;
      phase_d = PH_SOF;
      pos_d   = '0;
    end else if (bit_valid_i) begin
      unique case (phase_q)
        PH_SOF: begin
          if (!bit_i) begin
            phase_d     = PH_HEAD;
            pos_d       = POS_W'(1);
            data_d      = '0;
            crc_en_o    = 1'b1;
            crc_start_o = 1'b1;
          end else begin
            form_d = 1'b1;
          end
        end

        PH_HEAD: begin
          pos_d    = pos_q + POS_W'(1);
          crc_en_o = 1'b1;
          if (pos_q <= P_BASE_END) begin
            base_d = {base_q[ID_BASE_W-2:0], bit_i};
          end else if (pos_q == P_B12) begin
            b12_d = bit_i;
          end else if (pos_q == P_IDE) begin
            ide_d = bit_i;
          end else if (!ide_q) begin
            if (pos_q >= P_SDLC_BEG) dlc_d = dlc_full;
            if (pos_q == P_SDLC_END) begin
              rtr_d   = b12_q;
              last_d  = P_SDLC_END + data_span(dlc_full, b12_q);
              phase_d = PH_TAIL;
            end
          end else begin
            if (pos_q <= P_EID_END)
              ext_d = {ext_q[ID_EXT_W-2:0], bit_i};
            else if (pos_q == P_ERTR)
              rtr_d = bit_i;
            else if (pos_q >= P_EDLC_BEG)
              dlc_d = dlc_full;
            if (pos_q == P_EDLC_END) begin
              last_d  = P_EDLC_END + data_span(dlc_full, rtr_q);
              phase_d = PH_TAIL;
            end
          end
        end

        PH_TAIL: begin
          pos_d = pos_q + POS_W'(1);
          if (pos_q <= last_q) begin
            crc_en_o     = 1'b1;
            data_d[didx] = bit_i;
          end else if (rel <= O_CRC_END) begin
            crcrx_d = {crcrx_q[CRC_W-2:0], bit_i};
          end else if (rel == O_ACK) begin
            ack_d = !bit_i;
          end else if (!bit_i) begin
            // delimiters and end of frame must be recessive
            form_d  = 1'b1;
            phase_d = PH_SOF;
            pos_d   = '0;
          end else if (rel == O_EOF_LAST) begin
            done_d   = 1'b1;
            crcerr_d = (crc_calc_i != crcrx_q);
            phase_d  = PH_SOF;
            pos_d    = '0;
          end
        end

        default: begin
          phase_d = PH_SOF;
          pos_d   = '0;
        end
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_SOF;
      pos_q    <= '0;
      last_q   <= '0;
      base_q   <= '0;
      ext_q    <= '0;
      b12_q    <= 1'b0;
      ide_q    <= 1'b0;
      rtr_q    <= 1'b0;
      dlc_q    <= '0;
      data_q   <= '0;
      crcrx_q  <= '0;
      ack_q    <= 1'b0;
      crcerr_q <= 1'b0;
      done_q   <= 1'b0;
      form_q   <= 1'b0;
      stuff_q  <= 1'b0;
    end else begin
      done_q  <= done_d;
      form_q  <= form_d;
      stuff_q <= stuff_d;
      if (bit_valid_i || stuff_err_i) begin
        phase_q  <= phase_d;
        pos_q    <= pos_d;
        last_q   <= last_d;
        base_q   <= base_d;
        ext_q    <= ext_d;
        b12_q    <= b12_d;
        ide_q    <= ide_d;
        rtr_q    <= rtr_d;
        dlc_q    <= dlc_d;
        data_q   <= data_d;
        crcrx_q  <= crcrx_d;
        ack_q    <= ack_d;
        crcerr_q <= crcerr_d;
      end
    end
  end

  assign done_o      = done_q;
  assign id_o        = ide_q ? {base_q, ext_q} : {{ID_EXT_W{1'b0}}, base_q};
  assign ext_o       = ide_q;
  assign remote_o    = rtr_q;
  assign dlc_o       = dlc_q;
  assign data_o      = data_q;
  assign crc_rx_o    = crcrx_q;
  assign crc_err_o   = crcerr_q;
  assign ack_o       = ack_q;
  assign form_err_o  = form_q;
  assign stuff_err_o = stuff_q;

  // R2: without an accepted bit or a stuff error, the position holds
  a_r2_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid_i && !stuff_err_i) |=> $stable(pos_q));

  // R11: after frame done the parser is back waiting for start of frame
  a_r11_done_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == PH_SOF && pos_q == '0));

  // R10: a completed frame and an error never pulse together
  a_r10_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && (form_q || stuff_q)));

  // R6: the data field never runs past eight bytes
  a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TAIL) |-> (last_q <= MAX_LAST));

endmodule

// File: rtl/can_frame_parser.sv
module can_frame_parser
  import can_parse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              frame_done,
  output logic [ID_W-1:0]   frame_id,
  output logic              frame_ext,
  output logic              frame_remote,
  output logic [DLC_W-1:0]  frame_dlc,
  output logic [DATA_W-1:0] frame_data,
  output logic [CRC_W-1:0]  crc_rx,
  output logic              crc_error,
  output logic              ack_seen,
  output logic              form_error,
  output logic              stuff_error
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             ds_valid, ds_err;
  logic             restart, zone;
  logic             crc_en, crc_start;
  logic [CRC_W-1:0] crc_calc;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  can_bit_destuff u_destuff (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .in_valid_i  (bit_valid),
    .in_bit_i    (bit_in),
    .restart_i   (restart),
    .zone_i      (zone),
    .out_valid_o (ds_valid),
    .stuff_err_o (ds_err)
  );

  can_crc15 u_crc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en_i    (crc_en),
    .start_i (crc_start),
    .bit_i   (bit_in),
    .crc_o   (crc_calc)
  );

  can_field_track u_track (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .bit_valid_i (ds_valid),
    .bit_i       (bit_in),
    .stuff_err_i (ds_err),
    .crc_calc_i  (crc_calc),
    .restart_o   (restart),
    .zone_o      (zone),
    .crc_en_o    (crc_en),
    .crc_start_o (crc_start),
    .done_o      (frame_done),
    .id_o        (frame_id),
    .ext_o       (frame_ext),
    .remote_o    (frame_remote),
    .dlc_o       (frame_dlc),
    .data_o      (frame_data),
    .crc_rx_o    (crc_rx),
    .crc_err_o   (crc_error),
    .ack_o       (ack_seen),
    .form_err_o  (form_error),
    .stuff_err_o (stuff_error)
  );

endmodule

// File: tb/can_frame_parser_tb.sv
module can_frame_parser_tb;

  logic        clk;
  logic        rst_n;
  logic        bit_valid;
  logic        bit_in;
  logic        frame_done;
  logic [28:0] frame_id;
  logic        frame_ext;
  logic        frame_remote;
  logic [3:0]  frame_dlc;
  logic [63:0] frame_data;
  logic [14:0] crc_rx;
  logic        crc_error;
  logic        ack_seen;
  logic        form_error;
  logic        stuff_error;

  can_frame_parser u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_valid    (bit_valid),
    .bit_in       (bit_in),
    .frame_done   (frame_done),
    .frame_id     (frame_id),
    .frame_ext    (frame_ext),
    .frame_remote (frame_remote),
    .frame_dlc    (frame_dlc),
    .frame_data   (frame_data),
    .crc_rx       (crc_rx),
    .crc_error    (crc_error),
    .ack_seen     (ack_seen),
    .form_error   (form_error),
    .stuff_error  (stuff_error)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  typedef struct {
    logic [28:0] id;
    logic        ext;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
    logic [14:0] crc;
    logic        crc_err;
    logic        ack;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  int form_cnt = 0;
  int stuff_cnt = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (form_error)  form_cnt++;
      if (stuff_error) stuff_cnt++;
      if (frame_done) begin
        done_cnt++;
        if (exp_q.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R11 unexpected frame_done actual=1 expected=0");
        end else begin
          e = exp_q.pop_front();
          chk(e.ext ? "R5" : "R4", "frame_id",     64'(frame_id),     64'(e.id));
          chk(e.ext ? "R5" : "R4", "frame_ext",    64'(frame_ext),    64'(e.ext));
          chk(e.ext ? "R5" : "R4", "frame_remote", 64'(frame_remote), 64'(e.rtr));
          chk(e.ext ? "R5" : "R4", "frame_dlc",    64'(frame_dlc),    64'(e.dlc));
          chk("R6", "frame_data", frame_data, e.data);
          chk("R8", "crc_rx",     64'(crc_rx),    64'(e.crc));
          chk("R8", "crc_error",  64'(crc_error), 64'(e.crc_err));
          chk("R9", "ack_seen",   64'(ack_seen),  64'(e.ack));
        end
      end
    end
  end

  // Driver: one bus bit per strobe, inverted level while strobe is low (R2)
  task automatic send_bit(input bit b, input bit gaps);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in    = b;
    @(negedge clk);
    bit_valid = 1'b0;
    bit_in    = !b;
    if (gaps) repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input bit ext, input logic [28:0] id, input bit rtr,
                            input logic [3:0] dlc, input logic [63:0] data,
                            input bit ack, input bit rsv, input logic [14:0] crc_flip,
                            input bit bad_cdel, input bit gaps);
    bit raw[$];
    bit tx[$];
    logic [14:0] crc;
    logic [14:0] sent;
    logic [63:0] dexp;
    bit nxt;
    bit last;
    int run;
    int nb;
    exp_t e;

    raw.push_back(1'b0);
    if (ext) begin
      for (int i = 28; i >= 18; i--) raw.push_back(id[i]);
      raw.push_back(rsv);              // bit 12 in extended layout
      raw.push_back(1'b1);             // extended layout marker
      for (int i = 17; i >= 0; i--) raw.push_back(id[i]);
      raw.push_back(rtr);
      raw.push_back(rsv);
      raw.push_back(rsv);
    end else begin
      for (int i = 10; i >= 0; i--) raw.push_back(id[i]);
      raw.push_back(rtr);
      raw.push_back(1'b0);
      raw.push_back(rsv);
    end
    for (int i = 3; i >= 0; i--) raw.push_back(dlc[i]);
    nb = rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));
    for (int k = 0; k < nb * 8; k++) raw.push_back(data[63-k]);

    crc = '0;
    for (int i = 0; i < raw.size(); i++) begin
      nxt = raw[i] ^ crc[14];
      crc = {crc[13:0], 1'b0};
      if (nxt) crc = crc ^ 15'h4599;
    end
    sent = crc ^ crc_flip;
    for (int i = 14; i >= 0; i--) raw.push_back(sent[i]);

    run  = 0;
    last = 1'b1;
    for (int i = 0; i < raw.size(); i++) begin
      tx.push_back(raw[i]);
      if (i > 0 && raw[i] == last) run++;
      else run = 1;
      last = raw[i];
      if (run == 5) begin
        tx.push_back(!last);
        last = !last;
        run  = 1;
      end
    end

    tx.push_back(!bad_cdel);
    if (!bad_cdel) begin
      tx.push_back(!ack);
      tx.push_back(1'b1);
      for (int i = 0; i < 7; i++) tx.push_back(1'b1);

      dexp = '0;
      for (int k = 0; k < nb * 8; k++) dexp[63-k] = data[63-k];
      e.id      = ext ? id : {18'd0, id[10:0]};
      e.ext     = ext;
      e.rtr     = rtr;
      e.dlc     = dlc;
      e.data    = dexp;
      e.crc     = sent;
      e.crc_err = (crc_flip != 0);
      e.ack     = ack;
      exp_q.push_back(e);
    end

    for (int i = 0; i < tx.size(); i++) send_bit(tx[i], gaps);
    repeat (2) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int fc;
    int sc;
    int dc;
    bit_valid = 1'b0;
    bit_in    = 1'b1;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "frame_done", 64'(frame_done), 64'd0);
    chk("R1", "errors",     64'({form_error, stuff_error, crc_error, ack_seen}), 64'd0);
    chk("R1", "frame_id",   64'(frame_id), 64'd0);
    chk("R1", "frame_dlc",  64'(frame_dlc), 64'd0);
    chk("R1", "frame_data", frame_data, 64'd0);
    chk("R1", "crc_rx",     64'(crc_rx), 64'd0);

    // R4 standard data frame
    send_frame(0, 29'h123, 0, 4'd2, 64'hA55A_0000_0000_0000, 1, 0, 15'd0, 0, 0);
    // R6 standard remote frame: no data whatever the DLC
    send_frame(0, 29'h7F0, 1, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 15'd0, 0, 0);
    // R5 extended frame, R12 reserved bits recessive, R2 strobe gaps
    send_frame(1, 29'h1ABC_DE12, 0, 4'd8, 64'h0123_4567_89AB_CDEF, 1, 1, 15'd0, 0, 1);
    // R6 DLC above 8 gives eight bytes, R12 reserved bit recessive
    send_frame(0, 29'h055, 0, 4'd12, 64'hFEDC_BA98_7654_3210, 1, 1, 15'd0, 0, 0);
    // R5 extended remote, R9 no acknowledge
    send_frame(1, 29'h0000_0101, 1, 4'd3, 64'h0, 0, 0, 15'd0, 0, 0);
    // R7 long equal runs force heavy stuffing
    send_frame(0, 29'h000, 0, 4'd3, 64'h00FF_0000_0000_0000, 1, 0, 15'd0, 0, 0);
    send_frame(1, 29'h1FFF_FFFF, 0, 4'd1, 64'hFF00_0000_0000_0000, 1, 1, 15'd0, 0, 1);
    // R8 corrupted CRC sequence
    send_frame(0, 29'h321, 0, 4'd1, 64'h3C00_0000_0000_0000, 1, 0, 15'h0004, 0, 0);

    // R3 recessive bit while waiting for start of frame
    fc = form_cnt;
    dc = done_cnt;
    send_bit(1'b1, 0);
    @(negedge clk);
    chk("R3", "form_error count", 64'(form_cnt - fc), 64'd1);
    send_frame(0, 29'h2AA, 0, 4'd1, 64'h8100_0000_0000_0000, 1, 0, 15'd0, 0, 0);
    chk("R3", "frame after rejected SOF", 64'(done_cnt - dc), 64'd1);

    // R7 six dominant bits from start of frame
    sc = stuff_cnt;
    dc = done_cnt;
    for (int i = 0; i < 6; i++) send_bit(1'b0, 0);
    @(negedge clk);
    chk("R7", "stuff_error count", 64'(stuff_cnt - sc), 64'd1);
    send_frame(1, 29'h0ABC_0001, 0, 4'd2, 64'hBEEF_0000_0000_0000, 1, 0, 15'd0, 0, 0);
    chk("R7", "frame after stuff error", 64'(done_cnt - dc), 64'd1);

    // R10 dominant CRC delimiter
    fc = form_cnt;
    dc = done_cnt;
    send_frame(0, 29'h111, 0, 4'd1, 64'h5500_0000_0000_0000, 1, 0, 15'd0, 1, 0);
    @(negedge clk);
    chk("R10", "form_error count", 64'(form_cnt - fc), 64'd1);
    chk("R10", "no frame_done", 64'(done_cnt - dc), 64'd0);

    // R11 every good frame completed exactly once
    chk("R11", "pending expectations", 64'(exp_q.size()), 64'd0);
    chk("R11", "frames done", 64'(done_cnt), 64'd10);
    chk("R7", "no spurious stuff errors", 64'(stuff_cnt), 64'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule